// File: doc/BRIEF.md
# Sector Erase Collection Timer

The block gathers the target sectors of a multi-sector erase. It watches a stream of decoded commands, each with a valid strobe, a 2-bit command code and a sector index, together with a one-cycle tick that marks each microsecond. The first sector erase command opens a collection window. Each further sector erase command inside the window sets its sector's bit in a bitmap and restarts the window.

When a full window passes with no accepted command, or when an erase suspend command arrives during the window, the collection closes. The block then pulses a start signal for one cycle and presents the frozen bitmap. A status bit stays high from that point until the erase engine reports completion on a done input.

Any other command during the window discards the collected set and returns the block to read mode. The erase itself is carried out elsewhere.

Top module: `sect_collect`

## Requirements
- R1: After reset, `sector_map_o` is all zero and `start_o` and `expired_o` are low.
- R2: In read mode, a sector erase command (`cmd_i` = 2'b01 with `cmd_valid_i` high) opens the window, and the next cycle `sector_map_o` holds only the bit at position `sector_i`.
- R3: Inside the window, sector erase commands set their bits in any order. A sector already in the set changes nothing. Every sector can be collected at once.
- R4: The window expires on the `TIMEOUT_US`-th tick that follows the last accepted sector command. Each accepted sector command restarts the count from zero.
- R5: On expiry, `start_o` is high for exactly one cycle. That cycle is the first in which `expired_o` is high, and `sector_map_o` then holds the collected set.
- R6: A command that arrives in the same cycle as the expiring tick is rejected. The erase starts and the bitmap stays unchanged.
- R7: A command with a code other than sector erase or erase suspend (2'b00 or 2'b11) during the window clears `sector_map_o` and returns the block to read mode without a start.
- R8: An erase suspend command (`cmd_i` = 2'b10) during the window closes it at once. `start_o` is high in the next cycle and the set is kept.
- R9: While `expired_o` is high, commands and ticks are ignored and `sector_map_o` stays stable. A `done_i` pulse drops `expired_o` and clears the bitmap in the next cycle.
- R10: In read mode, erase suspend and other commands have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 2 | Command code: 01 sector erase, 10 erase suspend, 00/11 other |
| sector_i | input | $clog2(NUM_SECT) | Sector index of the command |
| tick_i | input | 1 | One-cycle microsecond tick |
| done_i | input | 1 | Erase finished, returns to read mode |
| sector_map_o | output | NUM_SECT | Collected sector bitmap, bit i = sector i |
| start_o | output | 1 | One-cycle erase start pulse |
| expired_o | output | 1 | Collection timer expired, erase in progress |

## Verification
Several sequences exercise collection: ascending indices, repeated indices, and all sectors at once. Comparing them separates a true bit-set from a last-write-wins register. A sector command placed one tick before the final tick is contrasted with one placed on the final tick, which shows whether accepted commands restart the window and whether expiry takes priority. A foreign command and a suspend command are each sent into an open window, which separates a discarded collection from an early start. A long random mix with sparse ticks and occasional done pulses then covers the cases where these events overlap.

// File: rtl/sect_pkg.sv
package sect_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER = 2'd0,
    CMD_SECT  = 2'd1,
    CMD_SUSP  = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_WIN   = 2'd1,
    ST_ERASE = 2'd2
  } st_e;
endpackage

// File: rtl/sect_tmr.sv
module sect_tmr #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sect_map.sv
module sect_map #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          set_i,
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  map_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = set_i && (idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    map_o[g] <= 1'b0;
      else if (clr_i) map_o[g] <= hit;
      else if (hit)   map_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sect_fsm.sv
module sect_fsm
  import sect_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  cmd_e cmd_i,
  input  logic expire_i,
  input  logic done_i,
  output logic map_clr_o,
  output logic map_set_o,
  output logic restart_o,
  output logic run_o,
  output logic start_o,
  output logic erase_o
);
  st_e  st_q, st_d;
  logic start_d;

  always_comb begin
    st_d      = st_q;
    start_d   = 1'b0;
    map_clr_o = 1'b0;
    map_set_o = 1'b0;
    restart_o = 1'b0;
    unique case (st_q)
      ST_READ: if (cmd_valid_i && cmd_i == CMD_SECT) begin
        map_clr_o = 1'b1;
        map_set_o = 1'b1;
        restart_o = 1'b1;
        st_d      = ST_WIN;
      end
      ST_WIN: begin
        if (expire_i) begin
          // expiry wins over a command on the same cycle
          st_d    = ST_ERASE;
          start_d = 1'b1;
        end else if (cmd_valid_i) begin
          unique case (cmd_i)
            CMD_SECT: begin
              map_set_o = 1'b1;
              restart_o = 1'b1;
            end
            CMD_SUSP: begin
              st_d    = ST_ERASE;
              start_d = 1'b1;
            end
            default: begin
              map_clr_o = 1'b1;
              st_d      = ST_READ;
            end
          endcase
        end
      end
      ST_ERASE: if (done_i) begin
        map_clr_o = 1'b1;
        st_d      = ST_READ;
      end
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_READ;
      start_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_o <= start_d;
    end
  end

  assign run_o   = (st_q == ST_WIN);
  assign erase_o = (st_q == ST_ERASE);
endmodule

// File: rtl/sect_collect.sv
module sect_collect
  import sect_pkg::*;
#(
  parameter int unsigned NUM_SECT   = 8,
  parameter int unsigned TIMEOUT_US = 50,
  localparam int unsigned SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_i,
  input  logic [SW-1:0]       sector_i,
  input  logic                tick_i,
  input  logic                done_i,
  output logic [NUM_SECT-1:0] sector_map_o,
  output logic                start_o,
  output logic                expired_o
);
  logic map_clr, map_set, tmr_restart, win_open, tmr_expire;

  sect_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_e'(cmd_i)),
    .expire_i   (tmr_expire),
    .done_i     (done_i),
    .map_clr_o  (map_clr),
    .map_set_o  (map_set),
    .restart_o  (tmr_restart),
    .run_o      (win_open),
    .start_o    (start_o),
    .erase_o    (expired_o)
  );

  sect_tmr #(.LIMIT(TIMEOUT_US)) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (win_open),
    .restart_i(tmr_restart),
    .tick_i   (tick_i),
    .expire_o (tmr_expire)
  );

  sect_map #(.N(NUM_SECT), .IW(SW)) i_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (map_clr),
    .set_i (map_set),
    .idx_i (sector_i),
    .map_o (sector_map_o)
  );
endmodule

// File: rtl/sect_collect_chk.sv
module sect_collect_chk #(
  parameter int unsigned NUM_SECT = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [1:0]          cmd_i,
  input logic                done_i,
  input logic [NUM_SECT-1:0] sector_map_o,
  input logic                start_o,
  input logic                expired_o,
  input logic                win_open,
  input logic                tmr_expire
);
  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_start_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (expired_o && !$past(expired_o)));

  p_map_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !done_i) |=> (expired_o && $stable(sector_map_o)));

  p_done_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && done_i) |=> (!expired_o && sector_map_o == '0));

  p_no_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && !(cmd_valid_i && cmd_i != 2'b01))
      |=> ((sector_map_o & $past(sector_map_o)) == $past(sector_map_o)));

  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && !tmr_expire && cmd_valid_i && (cmd_i == 2'b00 || cmd_i == 2'b11))
      |=> (sector_map_o == '0 && !expired_o && !win_open && !start_o));

  p_suspend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && cmd_valid_i && cmd_i == 2'b10) |=> start_o);

  p_one_state_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({win_open, expired_o}));
endmodule

bind sect_collect sect_collect_chk #(.NUM_SECT(NUM_SECT)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .done_i      (done_i),
  .sector_map_o(sector_map_o),
  .start_o     (start_o),
  .expired_o   (expired_o),
  .win_open    (win_open),
  .tmr_expire  (tmr_expire)
);

// File: tb/test_sect_collect.sv
module test_sect_collect;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int TO = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v = 1'b0;
  logic [1:0]    c = 2'b00;
  logic [2:0]    s = '0;
  logic          tk = 1'b0;
  logic          dn = 1'b0;
  logic [NS-1:0] map;
  logic          start, expired;

  int n_run = 0;
  int n_fail = 0;

  // reference model state: 0 read, 1 window, 2 erase
  int            m_st = 0;
  int            m_cnt = 0;
  logic [NS-1:0] m_map = '0;
  logic          m_start = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_collect #(.NUM_SECT(NS), .TIMEOUT_US(TO)) i_sect_collect (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(v), .cmd_i(c), .sector_i(s),
    .tick_i(tk), .done_i(dn), .sector_map_o(map), .start_o(start), .expired_o(expired)
  );

  function automatic logic [NS-1:0] bit_of(input logic [2:0] idx);
    return NS'(1) << idx;
  endfunction

  task automatic model_step();
    m_start = 1'b0;
    case (m_st)
      0: if (v && c == 2'b01) begin
        m_map = bit_of(s); m_cnt = 0; m_st = 1;
      end
      1: if (tk && m_cnt == TO - 1) begin
        m_st = 2; m_start = 1'b1;
      end else begin
        if (tk) m_cnt++;
        if (v) begin
          if (c == 2'b01) begin m_map |= bit_of(s); m_cnt = 0; end
          else if (c == 2'b10) begin m_st = 2; m_start = 1'b1; end
          else begin m_map = '0; m_st = 0; end
        end
      end
      default: if (dn) begin m_st = 0; m_map = '0; end
    endcase
  endtask

  task automatic cyc(input logic iv, input logic [1:0] ic, input logic [2:0] is,
                     input logic itk, input logic idn);
    v = iv; c = ic; s = is; tk = itk; dn = idn;
    @(posedge clk);
    model_step();
    @(negedge clk);
    v = 1'b0; tk = 1'b0; dn = 1'b0;
  endtask

  task automatic check(input string tag);
    n_run++;
    if (map !== m_map || start !== m_start || expired !== (m_st == 2)) begin
      n_fail++;
      $display("FAIL %s: map=%h start=%b expired=%b, expected map=%h start=%b expired=%b",
               tag, map, start, expired, m_map, m_start, (m_st == 2));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R10: suspend and foreign commands in read mode
    cyc(1, 2'b10, 3, 1, 0); check("R10");
    cyc(1, 2'b11, 3, 1, 0); check("R10");

    // R2: open window
    cyc(1, 2'b01, 5, 0, 0); check("R2");
    // R3: more sectors, duplicate
    cyc(1, 2'b01, 1, 0, 0); cyc(1, 2'b01, 5, 0, 0); cyc(1, 2'b01, 7, 0, 0); check("R3");

    // R4: restart keeps window open
    for (int i = 0; i < TO - 1; i++) cyc(0, 2'b00, 0, 1, 0);
    check("R4");
    cyc(1, 2'b01, 2, 0, 0);
    for (int i = 0; i < TO - 1; i++) cyc(0, 2'b00, 0, 1, 0);
    check("R4");
    cyc(0, 2'b00, 0, 1, 0); check("R5");
    idle(1); check("R5");

    // R9: ignored while expired, done clears
    cyc(1, 2'b01, 0, 1, 0); cyc(1, 2'b11, 0, 1, 0); check("R9");
    cyc(0, 2'b00, 0, 0, 1); check("R9");

    // R6: command on the expiring tick is rejected
    cyc(1, 2'b01, 0, 0, 0);
    for (int i = 0; i < TO - 1; i++) cyc(0, 2'b00, 0, 1, 0);
    cyc(1, 2'b01, 3, 1, 0); check("R6");
    cyc(0, 2'b00, 0, 0, 1);

    // R7: foreign command aborts
    cyc(1, 2'b01, 2, 0, 0); cyc(1, 2'b00, 0, 0, 0); check("R7");
    for (int i = 0; i < TO + 2; i++) cyc(0, 2'b00, 0, 1, 0);
    check("R7");

    // R8: suspend starts at once
    cyc(1, 2'b01, 4, 1, 0); cyc(1, 2'b10, 6, 0, 0); check("R8");
    cyc(0, 2'b00, 0, 0, 1);

    // R3: every sector
    for (int i = 0; i < NS; i++) cyc(1, 2'b01, 3'(NS - 1 - i), 0, 0);
    check("R3");
    cyc(1, 2'b10, 0, 0, 0); check("R8");
    cyc(0, 2'b00, 0, 0, 1); check("R9");

    // random mix
    void'($urandom(32'h5EC7));
    for (int i = 0; i < 4000; i++) begin
      logic rv, rt, rd;
      logic [1:0] rc;
      rv = ($urandom_range(0, 3) == 0);
      rc = ($urandom_range(0, 9) < 7) ? 2'b01 : 2'($urandom_range(0, 3));
      rt = ($urandom_range(0, 2) == 0);
      rd = ($urandom_range(0, 15) == 0);
      cyc(rv, rc, 3'($urandom_range(0, NS - 1)), rt, rd);
      check("R4");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule